// File: doc/BRIEF.md
# Directional Dual-Port Mailbox

This block passes bytes between two processors through two one-way channels. Each processor owns one port, A or B, and each port has its own clock and reset. The channel from A to B holds 128 bytes, and so does the channel from B to A. The most significant address bit of a port picks the channel. The lower seven bits pick a byte within it.

A port can only write its outgoing channel and only read its incoming channel. If an access uses the wrong value of the top address bit, it is dropped. A dropped write leaves every stored byte untouched. A dropped read returns zero while the output is still enabled.

The data output is never driven to high impedance inside the block. Instead, a per-port output-enable flag tells the pad logic whether the data is valid. A per-port idle flag reports that the port is deselected, so the pad logic can enter standby.

Top module: `dir_mailbox`

## Requirements
- R1: A write from port A with address bit 7 at 0 stores the data at word address[6:0] of the A-to-B channel. Port B reads that word back with address bit 7 at 0.
- R2: A write from port B with address bit 7 at 1 stores the data at word address[6:0] of the B-to-A channel. Port A reads that word back with address bit 7 at 1.
- R3: A write attempted from port A with address bit 7 at 1 changes no stored byte in either channel.
- R4: A write attempted from port B with address bit 7 at 0 changes no stored byte in either channel.
- R5: A read with the disallowed address bit 7 (0 on port A, 1 on port B) asserts the port's output-enable one cycle later and presents data 0x00.
- R6: While select_n is high, the port neither writes nor reads, whatever its strobes are. Its output-enable is low after the next clock edge.
- R7: A write (select_n low, write_n low) stores the data even when read_n is also low. The port's output-enable is low after that edge.
- R8: A read (select_n low, write_n high, read_n low) asserts output-enable after the port's next clock edge. The output then carries the addressed word.
- R9: With select_n low and both write_n and read_n high, no access takes place and output-enable is low after the next edge.
- R10: A port's idle output follows its select_n input with one cycle of delay: high after an edge that samples select_n high, low after an edge that samples it low.
- R11: During and right after reset, output-enable is low, the data output is 0x00, and idle is high on both ports.
- R12: The two ports run independently. In a single cycle, port A and port B can each write their own channel, or each read their own channel, without affecting the other port's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A active-low asynchronous reset |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_rd_n | input | 1 | Port A output strobe, active low |
| a_addr | input | 8 | Port A address; bit 7 picks the channel |
| a_wdata | input | 8 | Port A write data |
| a_rdata | output | 8 | Port A read data, 0x00 when not enabled |
| a_oe | output | 1 | Port A read data valid / drive enable |
| a_idle | output | 1 | Port A standby indication |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B active-low asynchronous reset |
| b_sel_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_rd_n | input | 1 | Port B output strobe, active low |
| b_addr | input | 8 | Port B address; bit 7 picks the channel |
| b_wdata | input | 8 | Port B write data |
| b_rdata | output | 8 | Port B read data, 0x00 when not enabled |
| b_oe | output | 1 | Port B read data valid / drive enable |
| b_idle | output | 1 | Port B standby indication |

## Verification
A wrong direction decode shows up as corrupted data. It appears at the latest on the first later read of the affected word from the receiving port. A wrong decode of the strobes shows up on output-enable or idle one clock edge after the stimulus. The bench reads back bytes that neighbour a rejected write, both through the channel that was aimed at and through the mirror address. It also holds every port's strobes in combinations where more than one strobe is active, so that a misdecoded strobe reaches the ports within one cycle.

// File: rtl/dmb_pkg.sv
package dmb_pkg;
    localparam int DMB_DATA_W = 8;
    localparam int DMB_ADDR_W = 8;

    // registered per-port output state
    typedef struct packed {
        logic oe;    // a read was accepted in the previous cycle
        logic ok;    // that read used the permitted direction
        logic idle;  // select was inactive in the previous cycle
    } dmb_port_st_t;

    localparam dmb_port_st_t DMB_PORT_RST = '{oe: 1'b0, ok: 1'b0, idle: 1'b1};
endpackage

// File: rtl/dmb_channel.sv
module dmb_channel #(
    parameter int DATA_W = 8,
    parameter int WORD_W = 7,
    localparam int DEPTH = 1 << WORD_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [WORD_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [WORD_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dmb_port.sv
module dmb_port
    import dmb_pkg::*;
#(
    parameter int   DATA_W = DMB_DATA_W,
    parameter int   ADDR_W = DMB_ADDR_W,
    parameter logic WR_HI  = 1'b0,
    localparam int  WORD_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_en,
    output logic [WORD_W-1:0] word,
    input  logic [DATA_W-1:0] chan_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              oe,
    output logic              idle
);
    dmb_port_st_t st_d, st_q;
    logic         hi_bit;
    logic         wr_req;
    logic         rd_req;

    always_comb begin
        hi_bit = addr[ADDR_W-1];
        wr_req = !sel_n && !wr_n;
        rd_req = !sel_n && wr_n && !rd_n;
        wr_en  = wr_req && (hi_bit == WR_HI);
        rd_en  = rd_req && (hi_bit != WR_HI);
        word   = addr[WORD_W-1:0];

        st_d      = st_q;
        st_d.oe   = rd_req;
        st_d.ok   = rd_en;
        st_d.idle = sel_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DMB_PORT_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe    = st_q.oe;
    assign idle  = st_q.idle;
    assign rdata = (st_q.oe && st_q.ok) ? chan_rdata : '0;
endmodule

// File: rtl/dir_mailbox.sv
module dir_mailbox
    import dmb_pkg::*;
#(
    parameter int  DATA_W = DMB_DATA_W,
    parameter int  ADDR_W = DMB_ADDR_W,
    localparam int WORD_W = ADDR_W - 1
) (
    input  logic              a_clk,
    input  logic              a_rst_n,
    input  logic              a_sel_n,
    input  logic              a_wr_n,
    input  logic              a_rd_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_oe,
    output logic              a_idle,
    input  logic              b_clk,
    input  logic              b_rst_n,
    input  logic              b_sel_n,
    input  logic              b_wr_n,
    input  logic              b_rd_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_oe,
    output logic              b_idle
);
    logic              a_wr_en, a_rd_en, b_wr_en, b_rd_en;
    logic [WORD_W-1:0] a_word, b_word;
    logic [DATA_W-1:0] ab_rdata, ba_rdata;

    // port A writes with bit 7 low, port B writes with bit 7 high
    dmb_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_HI(1'b0)) port_a_i (
        .clk(a_clk), .rst_n(a_rst_n), .sel_n(a_sel_n), .wr_n(a_wr_n),
        .rd_n(a_rd_n), .addr(a_addr), .wr_en(a_wr_en), .rd_en(a_rd_en),
        .word(a_word), .chan_rdata(ba_rdata), .rdata(a_rdata),
        .oe(a_oe), .idle(a_idle)
    );

    dmb_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_HI(1'b1)) port_b_i (
        .clk(b_clk), .rst_n(b_rst_n), .sel_n(b_sel_n), .wr_n(b_wr_n),
        .rd_n(b_rd_n), .addr(b_addr), .wr_en(b_wr_en), .rd_en(b_rd_en),
        .word(b_word), .chan_rdata(ab_rdata), .rdata(b_rdata),
        .oe(b_oe), .idle(b_idle)
    );

    dmb_channel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) chan_ab_i (
        .wclk(a_clk), .we(a_wr_en), .waddr(a_word), .wdata(a_wdata),
        .rclk(b_clk), .re(b_rd_en), .raddr(b_word), .rdata(ab_rdata)
    );

    dmb_channel #(.DATA_W(DATA_W), .WORD_W(WORD_W)) chan_ba_i (
        .wclk(b_clk), .we(b_wr_en), .waddr(b_word), .wdata(b_wdata),
        .rclk(a_clk), .re(a_rd_en), .raddr(a_word), .rdata(ba_rdata)
    );
endmodule

// File: rtl/dir_mailbox_chk.sv
module dir_mailbox_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              a_clk,
    input logic              a_rst_n,
    input logic              a_sel_n,
    input logic              a_wr_n,
    input logic              a_rd_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_oe,
    input logic              a_idle,
    input logic              b_clk,
    input logic              b_rst_n,
    input logic              b_sel_n,
    input logic              b_wr_n,
    input logic              b_rd_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_oe,
    input logic              b_idle
);
    a_r6_a_desel_quiet: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        a_sel_n |=> !a_oe);
    a_r6_b_desel_quiet: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        b_sel_n |=> !b_oe);

    a_r7_a_write_no_oe: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_sel_n && !a_wr_n) |=> !a_oe);
    a_r7_b_write_no_oe: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_sel_n && !b_wr_n) |=> !b_oe);

    a_r8_a_read_oe: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_sel_n && a_wr_n && !a_rd_n) |=> a_oe);
    a_r8_b_read_oe: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_sel_n && b_wr_n && !b_rd_n) |=> b_oe);

    a_r5_a_bad_read_zero: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_sel_n && a_wr_n && !a_rd_n && !a_addr[ADDR_W-1]) |=> (a_rdata == '0));
    a_r5_b_bad_read_zero: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_sel_n && b_wr_n && !b_rd_n && b_addr[ADDR_W-1]) |=> (b_rdata == '0));

    a_r9_a_nop_quiet: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        (!a_sel_n && a_wr_n && a_rd_n) |=> !a_oe);
    a_r9_b_nop_quiet: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        (!b_sel_n && b_wr_n && b_rd_n) |=> !b_oe);

    a_r10_a_idle_follow: assert property (@(posedge a_clk) disable iff (!a_rst_n)
        1'b1 |=> (a_idle == $past(a_sel_n)));
    a_r10_b_idle_follow: assert property (@(posedge b_clk) disable iff (!b_rst_n)
        1'b1 |=> (b_idle == $past(b_sel_n)));
endmodule

bind dir_mailbox dir_mailbox_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_sel_n(a_sel_n), .a_wr_n(a_wr_n),
    .a_rd_n(a_rd_n), .a_addr(a_addr), .a_rdata(a_rdata), .a_oe(a_oe),
    .a_idle(a_idle), .b_clk(b_clk), .b_rst_n(b_rst_n), .b_sel_n(b_sel_n),
    .b_wr_n(b_wr_n), .b_rd_n(b_rd_n), .b_addr(b_addr), .b_rdata(b_rdata),
    .b_oe(b_oe), .b_idle(b_idle)
);

// File: tb/dir_mailbox_tb_top.sv
module dir_mailbox_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_sel_n = 1'b1, a_wr_n = 1'b1, a_rd_n = 1'b1;
    logic [7:0] a_addr = '0, a_wdata = '0;
    logic       b_sel_n = 1'b1, b_wr_n = 1'b1, b_rd_n = 1'b1;
    logic [7:0] b_addr = '0, b_wdata = '0;
    logic [7:0] a_rdata, b_rdata;
    logic       a_oe, a_idle, b_oe, b_idle;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    dir_mailbox dut_i (
        .a_clk(clk), .a_rst_n(rst_n), .a_sel_n(a_sel_n), .a_wr_n(a_wr_n),
        .a_rd_n(a_rd_n), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .a_oe(a_oe), .a_idle(a_idle),
        .b_clk(clk), .b_rst_n(rst_n), .b_sel_n(b_sel_n), .b_wr_n(b_wr_n),
        .b_rd_n(b_rd_n), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_oe(b_oe), .b_idle(b_idle)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_a(input logic s, input logic w, input logic r,
                         input logic [7:0] ad, input logic [7:0] d);
        a_sel_n = s; a_wr_n = w; a_rd_n = r; a_addr = ad; a_wdata = d;
    endtask

    task automatic set_b(input logic s, input logic w, input logic r,
                         input logic [7:0] ad, input logic [7:0] d);
        b_sel_n = s; b_wr_n = w; b_rd_n = r; b_addr = ad; b_wdata = d;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic park();
        set_a(1, 1, 1, 8'h00, 8'h00);
        set_b(1, 1, 1, 8'h00, 8'h00);
    endtask

    task automatic wr_a(input logic [7:0] ad, input logic [7:0] d);
        set_a(0, 0, 1, ad, d); tick(); park();
    endtask

    task automatic wr_b(input logic [7:0] ad, input logic [7:0] d);
        set_b(0, 0, 1, ad, d); tick(); park();
    endtask

    task automatic rd_a_chk(input string req, input logic [7:0] ad,
                            input logic exp_oe, input logic [7:0] exp_d);
        set_a(0, 1, 0, ad, 8'h00); tick();
        check({req, " a_oe"}, {7'd0, a_oe}, {7'd0, exp_oe});
        check({req, " a_rdata"}, a_rdata, exp_d);
        park();
    endtask

    task automatic rd_b_chk(input string req, input logic [7:0] ad,
                            input logic exp_oe, input logic [7:0] exp_d);
        set_b(0, 1, 0, ad, 8'h00); tick();
        check({req, " b_oe"}, {7'd0, b_oe}, {7'd0, exp_oe});
        check({req, " b_rdata"}, b_rdata, exp_d);
        park();
    endtask

    task automatic t_reset();
        check("R11 a_oe", {7'd0, a_oe}, 8'd0);
        check("R11 b_oe", {7'd0, b_oe}, 8'd0);
        check("R11 a_rdata", a_rdata, 8'h00);
        check("R11 a_idle", {7'd0, a_idle}, 8'd1);
        check("R11 b_idle", {7'd0, b_idle}, 8'd1);
    endtask

    task automatic t_a_to_b();
        wr_a(8'h05, 8'h3C);
        wr_a(8'h7F, 8'hA5);
        wr_a(8'h00, 8'h81);
        rd_b_chk("R1 R8", 8'h05, 1'b1, 8'h3C);
        rd_b_chk("R1", 8'h7F, 1'b1, 8'hA5);
        rd_b_chk("R1", 8'h00, 1'b1, 8'h81);
    endtask

    task automatic t_b_to_a();
        wr_b(8'h85, 8'h5A);
        wr_b(8'hFF, 8'h96);
        rd_a_chk("R2 R8", 8'h85, 1'b1, 8'h5A);
        rd_a_chk("R2", 8'hFF, 1'b1, 8'h96);
    endtask

    task automatic t_bad_write();
        wr_a(8'h85, 8'hFF);
        rd_a_chk("R3 area2", 8'h85, 1'b1, 8'h5A);
        rd_b_chk("R3 area1", 8'h05, 1'b1, 8'h3C);
        wr_b(8'h05, 8'hEE);
        rd_b_chk("R4 area1", 8'h05, 1'b1, 8'h3C);
        rd_a_chk("R4 area2", 8'h85, 1'b1, 8'h5A);
    endtask

    task automatic t_bad_read();
        rd_a_chk("R5 port A", 8'h05, 1'b1, 8'h00);
        rd_b_chk("R5 port B", 8'h85, 1'b1, 8'h00);
    endtask

    task automatic t_deselect();
        wr_a(8'h10, 8'h11);
        set_a(1, 0, 0, 8'h10, 8'h77); tick();
        check("R6 a_oe", {7'd0, a_oe}, 8'd0);
        park();
        rd_b_chk("R6 no write", 8'h10, 1'b1, 8'h11);
        set_b(1, 1, 0, 8'h10, 8'h00); tick();
        check("R6 b_oe", {7'd0, b_oe}, 8'd0);
        park();
    endtask

    task automatic t_write_rd_low();
        set_a(0, 0, 0, 8'h20, 8'h42); tick();
        check("R7 a_oe", {7'd0, a_oe}, 8'd0);
        park();
        rd_b_chk("R7 stored", 8'h20, 1'b1, 8'h42);
    endtask

    task automatic t_nop();
        set_a(0, 1, 0, 8'h85, 8'h00); tick();
        check("R9 pre-read a_oe", {7'd0, a_oe}, 8'd1);
        set_a(0, 1, 1, 8'h85, 8'h00); tick();
        check("R9 a_oe", {7'd0, a_oe}, 8'd0);
        park();
    endtask

    task automatic t_idle();
        tick();
        check("R10 a idle high", {7'd0, a_idle}, 8'd1);
        set_a(0, 1, 1, 8'h00, 8'h00); tick();
        check("R10 a idle low", {7'd0, a_idle}, 8'd0);
        check("R10 b idle high", {7'd0, b_idle}, 8'd1);
        set_b(0, 1, 1, 8'h00, 8'h00); tick();
        check("R10 b idle low", {7'd0, b_idle}, 8'd0);
        park(); tick();
        check("R10 a idle back", {7'd0, a_idle}, 8'd1);
    endtask

    task automatic t_parallel();
        set_a(0, 0, 1, 8'h33, 8'hC3);
        set_b(0, 0, 1, 8'hB3, 8'h3C);
        tick();
        set_a(0, 1, 0, 8'hB3, 8'h00);
        set_b(0, 1, 0, 8'h33, 8'h00);
        tick();
        check("R12 a_rdata", a_rdata, 8'h3C);
        check("R12 b_rdata", b_rdata, 8'hC3);
        check("R12 oe both", {6'd0, a_oe, b_oe}, 8'd3);
        park();
    endtask

    initial begin
        park();
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_a_to_b();
        t_b_to_a();
        t_bad_write();
        t_bad_read();
        t_deselect();
        t_write_rd_low();
        t_nop();
        t_idle();
        t_parallel();
        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule